// File: doc/BRIEF.md
# Modulo-15 Up/Down Counter

This block is a synchronous 4-bit counter whose sequence runs through the fifteen values 0 to 14 and skips 15. One input picks the direction: when it is high the count rises and rolls from 14 back to 0. When it is low the count falls and rolls from 0 up to 14. It fits wherever a ring of fifteen slots has to be walked in either direction, such as a slot pointer or a phase index.

Every bit of state lives in its own flip-flop cell instance, and the next count is formed from plain gates. There is no behavioural register for the count as a whole. A build parameter picks the storage cell: a D cell, or a JK cell driven by set/clear terms taken from the same next-state vector. Both builds follow the same sequence.

The next-state logic makes one of four named transitions on each edge. STEP_UP adds one. STEP_DOWN subtracts one. WRAP_ZERO loads 0, either after 14 when counting up or out of the unreachable value 15. WRAP_TOP loads 14 after 0 when counting down. A synchronous, active-high reset overrides all four transitions and loads 0.

Top module: `mod15_updown_counter`

## Requirements
- R1: While `rst` is 1 at a rising edge of `clk`, `count` is 0 after that edge, whatever `dir_up` is.
- R2: With `rst` 0 and `dir_up` 1, a count of 0 to 13 becomes the count plus one at the next edge.
- R3: With `rst` 0 and `dir_up` 1, a count of 14 becomes 0 at the next edge.
- R4: With `rst` 0 and `dir_up` 0, a count of 1 to 14 becomes the count minus one at the next edge.
- R5: With `rst` 0 and `dir_up` 0, a count of 0 becomes 14 at the next edge.
- R6: After the first reset edge, `count` never shows the value 15.
- R7: `dir_up` is sampled at each rising edge and acts on that same edge. Reversing the direction between two edges moves the count back by one step and never skips a value.
- R8: When reset falls on the same edge as a wrap (count 0 going down, or 14 going up), the result is 0, not the wrap value.
- R9: The D-cell build (`CELL` = CELL_D) and the JK-cell build (`CELL` = CELL_JK) produce identical count sequences for the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, loads 0 |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| count | output | 4 | Current count, 0 to 14 |

## Verification
Reset and the direction wraps are the two functions that can fall on one edge. The bench sets this up by walking the count to 0 while counting down, or to 14 while counting up, and then raising `rst` for that single edge. The scoreboard expects 0 in both cases, not 14 or the rolled-over value. Direction reversals and the wrap points in both directions are also driven into both cell builds side by side, and each build is compared against the same expected queue.

// File: rtl/ctr15_pkg.sv
package ctr15_pkg;
    typedef enum logic {
        CELL_D  = 1'b0,
        CELL_JK = 1'b1
    } cell_e;

    typedef enum logic [1:0] {
        STEP_UP   = 2'd0,
        STEP_DOWN = 2'd1,
        WRAP_ZERO = 2'd2,
        WRAP_TOP  = 2'd3
    } move_e;
endpackage

// File: rtl/ctr15_dcell.sv
module ctr15_dcell (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
    end
endmodule

// File: rtl/ctr15_jkcell.sv
module ctr15_jkcell (
    input  logic clk,
    input  logic rst,
    input  logic j,
    input  logic k,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= (j & ~q) | (~k & q);
    end
endmodule

// File: rtl/ctr15_nextstate.sv
module ctr15_nextstate import ctr15_pkg::*; #(
    parameter int W = 4
) (
    input  logic         up,
    input  logic [W-1:0] q,
    output logic [W-1:0] nxt,
    output move_e        move
);
    logic [W-1:0] cy;
    logic [W-1:0] bw;
    logic [W-1:0] inc_v;
    logic [W-1:0] dec_v;
    logic [W-1:0] top_v;
    logic         illegal;
    logic         near_top;
    logic         at_zero;
    logic         sel_zero;
    logic         sel_top;
    logic         normal;

    assign cy[0] = 1'b1;
    assign bw[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign inc_v[i] = q[i] ^ cy[i];
        assign dec_v[i] = q[i] ^ bw[i];
        assign top_v[i] = (i == 0) ? 1'b0 : 1'b1;
        if (i < W - 1) begin : g_chain
            assign cy[i+1] = q[i] & cy[i];
            assign bw[i+1] = ~q[i] & bw[i];
        end
        assign nxt[i] = (normal & ((up & inc_v[i]) | (~up & dec_v[i])))
                      | (sel_top & top_v[i]);
    end

    assign illegal  = &q;
    assign near_top = &q[W-1:1];
    assign at_zero  = ~|q;
    assign sel_zero = illegal | (up & near_top);
    assign sel_top  = ~up & at_zero;
    assign normal   = ~sel_zero & ~sel_top;

    always_comb begin
        unique case ({sel_zero, sel_top})
            2'b10:   move = WRAP_ZERO;
            2'b01:   move = WRAP_TOP;
            default: move = up ? STEP_UP : STEP_DOWN;
        endcase
    end
endmodule

// File: rtl/mod15_updown_counter.sv
module mod15_updown_counter import ctr15_pkg::*; #(
    parameter int    W    = 4,
    parameter cell_e CELL = CELL_D
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dir_up,
    output logic [W-1:0] count
);
    logic [W-1:0] nxt;
    move_e        move;

    ctr15_nextstate #(.W(W)) ns_i (
        .up   (dir_up),
        .q    (count),
        .nxt  (nxt),
        .move (move)
    );

    for (genvar i = 0; i < W; i++) begin : g_cell
        if (CELL == CELL_JK) begin : g_jk
            ctr15_jkcell cell_i (
                .clk (clk),
                .rst (rst),
                .j   (nxt[i] & ~count[i]),
                .k   (~nxt[i] & count[i]),
                .q   (count[i])
            );
        end else begin : g_d
            ctr15_dcell cell_i (
                .clk (clk),
                .rst (rst),
                .d   (nxt[i]),
                .q   (count[i])
            );
        end
    end
endmodule

module ctr15_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         dir_up,
    input logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {{(W-1){1'b1}}, 1'b0};

    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> count == '0);

    // R6
    never_fifteen_chk: assert property (@(posedge clk) disable iff (rst) count != '1);

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (dir_up && count != TOP) |=> count == W'($past(count) + 1'b1));

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (dir_up && count == TOP) |=> count == '0);

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (!dir_up && count != '0) |=> count == W'($past(count) - 1'b1));

    // R5
    wrap_top_chk: assert property (@(posedge clk) disable iff (rst)
        (!dir_up && count == '0) |=> count == TOP);
endmodule

bind mod15_updown_counter ctr15_chk #(.W(W)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .dir_up (dir_up),
    .count  (count)
);

// File: tb/mod15_updown_counter_tb_top.sv
`timescale 1ns/1ps
module mod15_updown_counter_tb_top;
    import ctr15_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dir_up = 1'b1;
    logic [3:0] count_d;
    logic [3:0] count_jk;

    int    n_vec  = 0;
    int    n_bad  = 0;
    int    model  = 0;
    bit    done   = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    mod15_updown_counter #(.W(4), .CELL(CELL_D)) dut_i (
        .clk(clk), .rst(rst), .dir_up(dir_up), .count(count_d));

    mod15_updown_counter #(.W(4), .CELL(CELL_JK)) dut_jk_i (
        .clk(clk), .rst(rst), .dir_up(dir_up), .count(count_jk));

    task automatic step(input logic d, input logic r, input string tag);
        string t;
        @(negedge clk);
        dir_up = d;
        rst    = r;
        if (r)               begin model = 0; t = "R1"; end
        else if (d && model == 14) begin model = 0; t = "R3"; end
        else if (d)          begin model = model + 1; t = "R2"; end
        else if (model == 0) begin model = 14; t = "R5"; end
        else                 begin model = model - 1; t = "R4"; end
        if (tag != "") t = tag;
        exp_q.push_back(model);
        tag_q.push_back(t);
    endtask

    // monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_vec++;
                if (count_d !== 4'(e)) begin
                    n_bad++;
                    $display("FAIL %s D-cell count=%0d expected=%0d", t, count_d, e);
                end
                n_vec++;
                if (count_jk !== count_d) begin
                    n_bad++;
                    $display("FAIL R9 JK-cell count=%0d expected=%0d", count_jk, count_d);
                end
                n_vec++;
                if (count_d === 4'hF) begin
                    n_bad++;
                    $display("FAIL R6 count=%0d expected=not 15", count_d);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog count=%0d expected=finish", count_d);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(1'b1, 1'b1, "R1");
        step(1'b0, 1'b1, "R1");
        // R2 / R3: full upward lap plus wrap
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, "");
        // R4 / R5: full downward lap plus wrap
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0, "");
        // R7: reverse direction every edge and every second edge
        for (int i = 0; i < 10; i++) step(i[0], 1'b0, "R7");
        for (int i = 0; i < 12; i++) step(i[1], 1'b0, "R7");
        // R8: reset on the downward wrap edge
        step(1'b1, 1'b1, "R1");
        step(1'b0, 1'b1, "R8");
        step(1'b0, 1'b0, "R5");
        // R8: walk up to 14, then reset on the upward wrap edge
        while (model != 14) step(1'b1, 1'b0, "");
        step(1'b1, 1'b1, "R8");
        step(1'b1, 1'b0, "R2");
        // R7: reverse at the wrap points themselves
        step(1'b0, 1'b0, "R7");
        step(1'b0, 1'b0, "R5");
        step(1'b1, 1'b0, "R3");
        step(1'b0, 1'b0, "R5");
        @(negedge clk);
        rst = 1'b0;
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule